// File: doc/BRIEF.md
# Wake-up Frame Pattern Filter

This block watches the byte stream of a received Ethernet frame and decides, at the frame's last byte, whether the frame is a programmed wake-up frame. Three configuration values describe the pattern: a start offset into the frame, a 32-bit byte-select mask and a 16-bit signature. From the offset onward, every byte whose mask bit is set goes into a CRC-16 engine. The result is compared with the signature when the frame ends. On equality the block raises a one-cycle match pulse, provided the frame was reported good and contained every selected byte.

Byte positions are counted from the first byte of the destination address, which is position 0. The filter never looks at the two address fields: a programmed start offset below 12 is raised to 12. The frame arrives one byte per qualified cycle, with start-of-frame and end-of-frame markers and a good-frame flag that is valid on the last byte. An enable input stops the filter and clears its CRC state when deasserted.

Top module: `wkup_pattern_filter`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `wake_match` is 0.
- R2: A `cfg_offset` value below 12 behaves exactly like 12. A value of 12 or more is used as given.
- R3: Mask bit n (0 = LSB of `cfg_mask`) selects the byte at frame position E+n, where E is the effective offset. Only selected bytes change the CRC. A byte whose mask bit is clear does not change the outcome.
- R4: The CRC-16 uses the generator x^16+x^15+x^2+1. The register is shifted right with reflected constant 0xA001 and preset to 0xFFFF at each start-of-frame. Each byte is fed LSB first, and no final inversion is applied. Bytes "123456789" yield 0x4B37.
- R5: `wake_match` goes high for exactly one cycle, in the cycle after the end-of-frame byte is accepted, and never at any other time.
- R6: A frame whose `rx_good` is 0 on its end-of-frame byte produces no match.
- R7: A frame must contain position E+h, where h is the highest set mask bit (h = 0 for an empty mask). A frame that ends earlier produces no match, whatever its CRC.
- R8: While `en` is 0, the CRC state is held at 0xFFFF, any frame in progress is dropped, and no match is produced. A frame that starts after `en` returns is filtered normally.
- R9: Cycles with `rx_valid` 0 are ignored whatever the other receive inputs carry. Valid bytes outside a frame (before any start-of-frame) are ignored. A new start-of-frame restarts the position count and the CRC.
- R10: A frame whose CRC over the selected bytes differs from `cfg_crc` produces no match.
- R11: Bytes at position E+32 and beyond never affect the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Filter enable |
| cfg_offset | input | 8 | Start offset of the pattern window in the frame |
| cfg_mask | input | 32 | Byte-select mask for window positions 0..31 |
| cfg_crc | input | 16 | Expected CRC-16 signature |
| rx_valid | input | 1 | Receive byte qualifier |
| rx_data | input | 8 | Receive byte |
| rx_sof | input | 1 | Marks the first byte of a frame |
| rx_eof | input | 1 | Marks the last byte of a frame |
| rx_good | input | 1 | Frame status, sampled with the end-of-frame byte |
| wake_match | output | 1 | One-cycle wake-up frame detection pulse |

## Verification
The hardest case to reach is a frame whose CRC is correct but which stops one byte short of the highest selected position. The bench builds it by setting the signature to the CRC of exactly the bytes that did arrive, and then sends the same frame one byte longer. A second hard case is the enable being dropped and restored in mid-frame. For this, the bench toggles `en` in the middle of the byte loop and then sends a clean frame to show the CRC restarts. Sweeps over offsets 0..24 with several masks, plus single-byte changes at selected, unselected and out-of-window positions, cover the window arithmetic.

// File: rtl/wkf_pkg.sv
package wkf_pkg;

    localparam int DEF_OFS_W   = 8;
    localparam int DEF_MASK_W  = 32;
    localparam int DEF_MIN_OFS = 12;
    localparam int CRC_W       = 16;
    localparam int BYTE_W      = 8;

    localparam logic [CRC_W-1:0] CRC_PRESET    = 16'hFFFF;
    localparam logic [CRC_W-1:0] CRC_POLY_REFL = 16'hA001;

    typedef struct packed {
        logic              valid;
        logic              sof;
        logic              eof;
        logic              good;
        logic [BYTE_W-1:0] data;
    } rx_beat_t;

    typedef enum logic [0:0] {
        PH_IDLE  = 1'b0,
        PH_FRAME = 1'b1
    } phase_e;

    // One byte through the reflected CRC register, least significant bit first.
    function automatic logic [CRC_W-1:0] crc_step_byte(
        input logic [CRC_W-1:0]  c,
        input logic [BYTE_W-1:0] d
    );
        logic [CRC_W-1:0] r;
        r = c;
        for (int b = 0; b < BYTE_W; b++) begin
            if (r[0] ^ d[b]) r = (r >> 1) ^ CRC_POLY_REFL;
            else             r = r >> 1;
        end
        return r;
    endfunction

endpackage

// File: rtl/wkf_pos_track.sv
module wkf_pos_track
    import wkf_pkg::*;
#(
    parameter int OFS_W   = DEF_OFS_W,
    parameter int MASK_W  = DEF_MASK_W,
    parameter int MIN_OFS = DEF_MIN_OFS
)
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              accept,
    input  logic              start,
    input  logic [OFS_W-1:0]  offset,
    input  logic [MASK_W-1:0] mask,
    output logic              sel,
    output logic              reached
);
    localparam int POS_W = $clog2((2 ** OFS_W) + MASK_W + 1);
    localparam int IDX_W = $clog2(MASK_W);
    localparam logic [POS_W-1:0] POS_MAX = '1;

    logic [POS_W-1:0] pos_q;
    logic [POS_W-1:0] pos_cur;
    logic [POS_W-1:0] eff_ofs;
    logic [POS_W-1:0] hi_idx;
    logic [POS_W-1:0] need_pos;
    logic [POS_W-1:0] rel;
    logic             in_win;

    always_comb begin
        if (POS_W'(offset) < POS_W'(MIN_OFS)) eff_ofs = POS_W'(MIN_OFS);
        else                                  eff_ofs = POS_W'(offset);
    end

    always_comb begin
        hi_idx = '0;
        for (int n = 0; n < MASK_W; n++) begin
            if (mask[n]) hi_idx = POS_W'(n);
        end
    end

    always_comb begin
        need_pos = eff_ofs + hi_idx;
        pos_cur  = start ? '0 : pos_q;
        rel      = pos_cur - eff_ofs;
        in_win   = (pos_cur >= eff_ofs) && (rel < POS_W'(MASK_W));
        sel      = in_win && mask[rel[IDX_W-1:0]];
        reached  = (pos_cur >= need_pos);
    end

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            pos_q <= '0;
        end else if (accept) begin
            pos_q <= (pos_cur == POS_MAX) ? POS_MAX : pos_cur + 1'b1;
        end
    end

endmodule

// File: rtl/wkf_crc_unit.sv
module wkf_crc_unit
    import wkf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              start,
    input  logic              accept,
    input  logic              upd,
    input  logic [BYTE_W-1:0] data,
    output logic [CRC_W-1:0]  crc_q,
    output logic [CRC_W-1:0]  crc_next
);
    logic [CRC_W-1:0] crc_base;

    always_comb begin
        crc_base = start ? CRC_PRESET : crc_q;
        crc_next = upd ? crc_step_byte(crc_base, data) : crc_base;
    end

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            crc_q <= CRC_PRESET;
        end else if (accept) begin
            crc_q <= crc_next;
        end
    end

endmodule

// File: rtl/wkf_frame_ctl.sv
module wkf_frame_ctl
    import wkf_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  rx_beat_t         beat,
    input  logic [CRC_W-1:0] cfg_crc,
    input  logic [CRC_W-1:0] crc_next,
    input  logic             reached,
    output logic             accept,
    output logic             start,
    output logic             wake_match
);
    phase_e ph_q;
    logic   hit;

    always_comb begin
        start  = beat.valid && beat.sof;
        accept = beat.valid && (beat.sof || (ph_q == PH_FRAME));
        hit    = accept && beat.eof && beat.good && reached && (crc_next == cfg_crc);
    end

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            ph_q <= PH_IDLE;
        end else if (accept) begin
            ph_q <= beat.eof ? PH_IDLE : PH_FRAME;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !en) wake_match <= 1'b0;
        else            wake_match <= hit;
    end

endmodule

// File: rtl/wkup_pattern_filter.sv
module wkup_pattern_filter
    import wkf_pkg::*;
#(
    parameter int OFS_W   = DEF_OFS_W,
    parameter int MASK_W  = DEF_MASK_W,
    parameter int MIN_OFS = DEF_MIN_OFS
)
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic [OFS_W-1:0]  cfg_offset,
    input  logic [MASK_W-1:0] cfg_mask,
    input  logic [CRC_W-1:0]  cfg_crc,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_data,
    input  logic              rx_sof,
    input  logic              rx_eof,
    input  logic              rx_good,
    output logic              wake_match
);
    rx_beat_t         beat;
    logic             accept;
    logic             start;
    logic             sel;
    logic             reached;
    logic [CRC_W-1:0] crc_q;
    logic [CRC_W-1:0] crc_next;

    always_comb begin
        beat.valid = rx_valid;
        beat.sof   = rx_sof;
        beat.eof   = rx_eof;
        beat.good  = rx_good;
        beat.data  = rx_data;
    end

    wkf_pos_track #(
        .OFS_W   (OFS_W),
        .MASK_W  (MASK_W),
        .MIN_OFS (MIN_OFS)
    ) u_pos (
        .clk     (clk),
        .rst     (rst),
        .en      (en),
        .accept  (accept),
        .start   (start),
        .offset  (cfg_offset),
        .mask    (cfg_mask),
        .sel     (sel),
        .reached (reached)
    );

    wkf_crc_unit u_crc (
        .clk      (clk),
        .rst      (rst),
        .en       (en),
        .start    (start),
        .accept   (accept),
        .upd      (sel && accept),
        .data     (beat.data),
        .crc_q    (crc_q),
        .crc_next (crc_next)
    );

    wkf_frame_ctl u_ctl (
        .clk        (clk),
        .rst        (rst),
        .en         (en),
        .beat       (beat),
        .cfg_crc    (cfg_crc),
        .crc_next   (crc_next),
        .reached    (reached),
        .accept     (accept),
        .start      (start),
        .wake_match (wake_match)
    );

endmodule

// File: rtl/wkf_checker.sv
module wkf_checker (
    input logic        clk,
    input logic        rst,
    input logic        en,
    input logic        rx_valid,
    input logic        rx_eof,
    input logic        rx_good,
    input logic        wake_match,
    input logic [15:0] crc_state
);
    assert_idle_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !wake_match);

    assert_single_pulse_R5: assert property (@(posedge clk) disable iff (rst)
        wake_match |=> !wake_match);

    assert_follows_eof_R5: assert property (@(posedge clk) disable iff (rst)
        wake_match |-> $past(rx_valid && rx_eof));

    assert_good_frame_only_R6: assert property (@(posedge clk) disable iff (rst)
        wake_match |-> $past(rx_good));

    assert_enable_gates_match_R8: assert property (@(posedge clk) disable iff (rst)
        wake_match |-> $past(en));

    assert_crc_held_when_off_R8: assert property (@(posedge clk) disable iff (rst)
        !en |=> (crc_state == 16'hFFFF));
endmodule

bind wkup_pattern_filter wkf_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .en         (en),
    .rx_valid   (rx_valid),
    .rx_eof     (rx_eof),
    .rx_good    (rx_good),
    .wake_match (wake_match),
    .crc_state  (crc_q)
);

// File: tb/sim_wkup_pattern_filter.sv
module sim_wkup_pattern_filter;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en = 1'b1;
    logic [7:0]  cfg_offset = 8'd12;
    logic [31:0] cfg_mask = 32'h0;
    logic [15:0] cfg_crc = 16'h0;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_data = 8'h0;
    logic        rx_sof = 1'b0;
    logic        rx_eof = 1'b0;
    logic        rx_good = 1'b0;
    logic        wake_match;

    int tests = 0;
    int fails = 0;
    bit done = 0;
    logic [7:0] fr [0:127];

    always #5 clk = ~clk;

    wkup_pattern_filter u0 (
        .clk(clk), .rst(rst), .en(en),
        .cfg_offset(cfg_offset), .cfg_mask(cfg_mask), .cfg_crc(cfg_crc),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_sof(rx_sof),
        .rx_eof(rx_eof), .rx_good(rx_good), .wake_match(wake_match)
    );

    function automatic logic [15:0] rev16(input logic [15:0] v);
        logic [15:0] o;
        for (int i = 0; i < 16; i++) o[i] = v[15-i];
        return o;
    endfunction

    // Left-shifting register on the mirrored value, generator 0x8005.
    function automatic logic [15:0] ref_feed(input logic [15:0] c, input logic [7:0] d);
        logic [15:0] m;
        logic        fb;
        m = rev16(c);
        for (int b = 0; b < 8; b++) begin
            fb = m[15] ^ d[b];
            m  = m << 1;
            if (fb) m = m ^ 16'h8005;
        end
        return rev16(m);
    endfunction

    function automatic int eff_of(input logic [7:0] ofs);
        return (ofs < 8'd12) ? 12 : int'(ofs);
    endfunction

    function automatic logic [15:0] calc_crc(input int len, input logic [7:0] ofs, input logic [31:0] mask);
        logic [15:0] c;
        int e;
        c = 16'hFFFF;
        e = eff_of(ofs);
        for (int i = 0; i < 32; i++) begin
            if (mask[i] && (e + i < len)) c = ref_feed(c, fr[e+i]);
        end
        return c;
    endfunction

    function automatic logic exp_match(input int len, input logic [7:0] ofs, input logic [31:0] mask,
                                       input logic good, input logic [15:0] sig);
        int h;
        h = 0;
        for (int i = 0; i < 32; i++) if (mask[i]) h = i;
        if (!good) return 1'b0;
        if (len - 1 < eff_of(ofs) + h) return 1'b0;
        return calc_crc(len, ofs, mask) == sig;
    endfunction

    task automatic check(input logic act, input logic expv, input string tag);
        tests++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s: wake_match=%0b expected %0b", tag, act, expv);
        end
    endtask

    task automatic fill_random();
        for (int i = 0; i < 128; i++) fr[i] = 8'($urandom);
    endtask

    task automatic idle_inputs();
        rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0; rx_good = 1'b0;
    endtask

    // Sends fr[0..len-1]; dis_at >= 0 drops en at that byte and restores it two bytes later.
    task automatic run_frame(input int len, input logic good, input bit gaps,
                             input int dis_at, input logic expv, input string tag);
        bit stray;
        stray = 0;
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            if (wake_match) stray = 1;
            if (i == dis_at) en = 1'b0;
            if (dis_at >= 0 && i == dis_at + 2) en = 1'b1;
            rx_valid = 1'b1; rx_data = fr[i];
            rx_sof = (i == 0); rx_eof = (i == len - 1); rx_good = good;
            if (gaps && (i % 3 == 1) && (i != len - 1)) begin
                @(negedge clk);
                if (wake_match) stray = 1;
                rx_valid = 1'b0; rx_data = 8'($urandom);
                rx_sof = 1'b1; rx_eof = 1'b1; rx_good = 1'b1;
            end
        end
        @(negedge clk);
        check(wake_match, expv, tag);
        idle_inputs();
        en = 1'b1;
        @(negedge clk);
        check(wake_match | stray, 1'b0, "R5 pulse width / no stray pulse");
    endtask

    task automatic sweep_case(input int len, input logic [7:0] ofs, input logic [31:0] mask);
        logic e;
        cfg_offset = ofs; cfg_mask = mask;
        cfg_crc = calc_crc(len, ofs, mask);
        e = exp_match(len, ofs, mask, 1'b1, cfg_crc);
        run_frame(len, 1'b1, 0, -1, e, (ofs < 8'd12) ? "R2 clamped offset" : "R3 window select");
        cfg_crc = cfg_crc ^ 16'h0100;
        e = exp_match(len, ofs, mask, 1'b1, cfg_crc);
        run_frame(len, 1'b1, 0, -1, e, "R10 signature mismatch");
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] masks [0:3];
        logic e;
        masks[0] = 32'h0000_0001;
        masks[1] = 32'h8000_0001;
        masks[2] = 32'hA5A5_0F0F;
        masks[3] = 32'hFFFF_FFFF;

        repeat (4) @(negedge clk);
        check(wake_match, 1'b0, "R1 during reset");
        rst = 1'b0;
        @(negedge clk);
        check(wake_match, 1'b0, "R1 after reset");

        // R4 known vector "123456789" -> 0x4B37
        fill_random();
        for (int k = 0; k < 9; k++) fr[12+k] = 8'h31 + 8'(k);
        cfg_offset = 8'd12; cfg_mask = 32'h0000_01FF; cfg_crc = 16'h4B37;
        run_frame(30, 1'b1, 0, -1, 1'b1, "R4 check vector");
        cfg_offset = 8'd3;
        run_frame(30, 1'b1, 0, -1, 1'b1, "R2 offset 3 acts as 12");

        // Offset and mask sweep
        for (int ofs = 0; ofs <= 24; ofs++) begin
            for (int m = 0; m < 4; m++) begin
                fill_random();
                sweep_case(64, 8'(ofs), masks[m]);
            end
        end

        // R3: unselected byte changed keeps match, selected byte changed breaks it
        fill_random();
        cfg_offset = 8'd16; cfg_mask = 32'h0000_0005;
        cfg_crc = calc_crc(40, 8'd16, 32'h5);
        fr[17] = ~fr[17];
        run_frame(40, 1'b1, 0, -1, 1'b1, "R3 unselected byte ignored");
        fr[18] = ~fr[18];
        e = exp_match(40, 8'd16, 32'h5, 1'b1, cfg_crc);
        run_frame(40, 1'b1, 0, -1, e, "R3 selected byte counted");

        // R11: byte at E+32 outside window
        fill_random();
        cfg_offset = 8'd14; cfg_mask = 32'hFFFF_FFFF;
        cfg_crc = calc_crc(64, 8'd14, 32'hFFFF_FFFF);
        fr[46] = ~fr[46];
        fr[50] = ~fr[50];
        run_frame(64, 1'b1, 0, -1, 1'b1, "R11 beyond window ignored");

        // R6: bad frame
        run_frame(64, 1'b0, 0, -1, 1'b0, "R6 bad frame suppressed");

        // R7: frame one byte short of the last selected position (E+16 = 36)
        fill_random();
        cfg_offset = 8'd20; cfg_mask = 32'h0001_0001;
        cfg_crc = calc_crc(36, 8'd20, 32'h0001_0001);
        run_frame(36, 1'b1, 0, -1, 1'b0, "R7 short frame suppressed");
        cfg_crc = calc_crc(37, 8'd20, 32'h0001_0001);
        run_frame(37, 1'b1, 0, -1, 1'b1, "R7 frame just long enough");
        cfg_mask = 32'h0;
        cfg_crc = 16'hFFFF;
        run_frame(20, 1'b1, 0, -1, 1'b0, "R7 empty mask, frame ends before offset");
        run_frame(21, 1'b1, 0, -1, 1'b1, "R7 empty mask, frame reaches offset");

        // R8: enable
        fill_random();
        cfg_offset = 8'd12; cfg_mask = 32'h00FF_00FF;
        cfg_crc = calc_crc(48, 8'd12, 32'h00FF_00FF);
        en = 1'b0;
        begin
            for (int i = 0; i < 48; i++) begin
                @(negedge clk);
                en = 1'b0;
                rx_valid = 1'b1; rx_data = fr[i];
                rx_sof = (i == 0); rx_eof = (i == 47); rx_good = 1'b1;
            end
            @(negedge clk);
            check(wake_match, 1'b0, "R8 disabled frame");
            idle_inputs();
            en = 1'b1;
            @(negedge clk);
        end
        run_frame(48, 1'b1, 0, 20, 1'b0, "R8 enable dropped mid-frame");
        run_frame(48, 1'b1, 0, -1, 1'b1, "R8 filtering resumes");

        // R9: idle cycles with garbage, stray bytes, restart by new start
        run_frame(48, 1'b1, 1, -1, 1'b1, "R9 invalid cycles ignored");
        for (int i = 0; i < 50; i++) begin
            @(negedge clk);
            rx_valid = 1'b1; rx_data = fr[i]; rx_sof = 1'b0;
            rx_eof = (i == 47); rx_good = 1'b1;
        end
        @(negedge clk);
        idle_inputs();
        check(wake_match, 1'b0, "R9 bytes outside frame ignored");
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            rx_valid = 1'b1; rx_data = 8'($urandom); rx_sof = (i == 0);
            rx_eof = 1'b0; rx_good = 1'b1;
        end
        run_frame(48, 1'b1, 0, -1, 1'b1, "R9 new start restarts frame");

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule